// File: doc/BRIEF.md
# Odd-Ones and Double-Zero Serial Monitor

This block watches a serial bit stream, taking one bit per clock, and raises a single flag when two facts both hold about everything received since the last reset. First, an odd number of 1s has arrived. Second, at some point the stream held two 0s back to back. The monitor keeps three bits of state: a running parity of the 1s, the value of the previous bit (was it a 0), and a sticky bit that records a double zero.

The output is Moore style. It depends only on the stored state, so a bit presented on one edge shows up in the flag after that edge. The flag is held in a register. It is loaded with the value the state will have after the edge, so it always equals parity AND sticky-bit for the stored state. The block never returns to its initial state on its own. After the flag goes high, the parity keeps toggling with each further 1 and the flag follows it. Only the synchronous active-high reset clears the tracking.

Top module: `onesz_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, and right after that edge, `flag_out` is 0.
- R2: A 0 on `serial_bit` leaves the stored parity unchanged, and a 1 inverts it. The parity is observable through `flag_out` once a double zero has been seen.
- R3: The double-zero condition becomes true only on the edge that takes in a 0 whose immediately preceding accepted bit was also a 0. Single 0s separated by 1s never set it.
- R4: Once the double-zero condition is set, it stays set on every later edge until reset.
- R5: After each edge, `flag_out` is 1 exactly when the bits accepted since reset contain an odd count of 1s and include two consecutive 0s. This covers the bit taken on that edge and no later bit.
- R6: Reset clears the previous-bit history. A 0 accepted before reset and a 0 accepted right after it do not count as a pair.
- R7: After `flag_out` has gone high, tracking continues without any restart. For example, another 1 drives `flag_out` low and the next 1 drives it high again.
- R8: Starting from reset, apply the stream 1,0,1,1,0,0,1,1. Read `flag_out` just before each of those bits is taken: it is 0,0,0,0,0,0,1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serial_bit | input | 1 | Stream bit, sampled once per rising edge |
| flag_out | output | 1 | Registered result: odd count of 1s and a double zero seen |

## Verification
The embedded assertions check several rules on every cycle: the parity holds on a 0 and flips on a 1, the double-zero bit is sticky, and that bit rises only after two consecutive accepted 0s. They also check that the registered flag always equals the AND of the stored parity and the sticky bit, and that it is low after any reset edge. What the assertions cannot show is that the combined behaviour matches the requirements over a whole stream. The bench covers this with its scenarios: the worked example, reset landing between two 0s, long runs of 1s after the flag has gone high, and random streams with resets mixed in, all compared against a bench-side model.

// File: rtl/onesz_pkg.sv
package onesz_pkg;

  // Stored state of the monitor, bundled for readability at the top level.
  typedef struct packed {
    logic odd_ones;   // parity of 1s accepted since reset
    logic dz_seen;    // sticky: two consecutive 0s have been accepted
    logic last_zero;  // previous accepted bit was 0
  } mon_state_t;

  localparam logic PARITY_EVEN = 1'b0;

endpackage

// File: rtl/onesz_parity.sv
module onesz_parity
  import onesz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic odd_q,
  output logic odd_next
);

  assign odd_next = odd_q ^ bit_in;

  always_ff @(posedge clk) begin
    if (rst) odd_q <= PARITY_EVEN;
    else     odd_q <= odd_next;
  end

  // R2: a 0 keeps the parity, a 1 flips it
  assert_parity_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_in == 1'b0) |=> (odd_q == $past(odd_q)));
  assert_parity_flip_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_in == 1'b1) |=> (odd_q != $past(odd_q)));

endmodule

// File: rtl/onesz_zero_run.sv
module onesz_zero_run (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic dz_q,
  output logic dz_next,
  output logic last_zero_q
);

  assign dz_next = dz_q | (last_zero_q & ~bit_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      dz_q        <= 1'b0;
      last_zero_q <= 1'b0;
    end else begin
      dz_q        <= dz_next;
      last_zero_q <= ~bit_in;
    end
  end

  // R4: the double-zero bit never falls outside reset
  assert_dz_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    dz_q |=> dz_q);
  // R3: two consecutive 0s set the bit
  assert_dz_set_R3: assert property (@(posedge clk) disable iff (rst)
    (last_zero_q && !bit_in) |=> dz_q);
  // R3: the bit rises only after a 0 preceded by a 0
  assert_dz_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dz_q) |-> ($past(last_zero_q) && !$past(bit_in)));

endmodule

// File: rtl/onesz_out_reg.sv
module onesz_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic odd_next,
  input  logic dz_next,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= odd_next & dz_next;
  end

  // R1: any reset edge leaves the flag low
  assert_flag_reset_R1: assert property (@(posedge clk)
    rst |=> !flag_q);

endmodule

// File: rtl/onesz_monitor.sv
module onesz_monitor
  import onesz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serial_bit,
  output logic flag_out
);

  mon_state_t st;
  logic       odd_next;
  logic       dz_next;

  onesz_parity u_parity (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (serial_bit),
    .odd_q    (st.odd_ones),
    .odd_next (odd_next)
  );

  onesz_zero_run u_zero_run (
    .clk         (clk),
    .rst         (rst),
    .bit_in      (serial_bit),
    .dz_q        (st.dz_seen),
    .dz_next     (dz_next),
    .last_zero_q (st.last_zero)
  );

  onesz_out_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .odd_next (odd_next),
    .dz_next  (dz_next),
    .flag_q   (flag_out)
  );

  // R5: the registered flag tracks the AND of the stored state bits
  assert_flag_state_R5: assert property (@(posedge clk) disable iff (rst)
    flag_out == (st.odd_ones & st.dz_seen));
  // R7: once high, a 1 lowers the flag and tracking keeps going
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_out && serial_bit) |=> (!flag_out && st.dz_seen));

endmodule

// File: tb/onesz_monitor_tb.sv
`timescale 1ns/1ps
module onesz_monitor_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_bit = 1'b0;
  logic flag_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  bit m_odd = 0, m_dz = 0, m_lz = 0;

  always #4 clk = ~clk;

  onesz_monitor dut_i (
    .clk        (clk),
    .rst        (rst),
    .serial_bit (serial_bit),
    .flag_out   (flag_out)
  );

  function automatic bit model_flag();
    return m_odd & m_dz;
  endfunction

  task automatic check(input bit exp, input string req);
    checks++;
    if (flag_out !== exp) begin
      errors++;
      $display("FAIL %s: flag_out=%b expected=%b at %0t", req, flag_out, exp, $time);
    end
  endtask

  task automatic do_reset(input bit xval);
    serial_bit = xval;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
    m_odd = 0; m_dz = 0; m_lz = 0;
  endtask

  task automatic step(input bit b, input string req);
    serial_bit = b;
    @(posedge clk);
    if (m_lz && !b) m_dz = 1;
    m_lz = !b;
    m_odd = m_odd ^ b;
    @(negedge clk);
    check(model_flag(), req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [7:0] ex_in;
    bit [7:0] ex_out;
    void'($urandom(32'h5EED_0A11));
    ex_in  = 8'b1011_0011;   // MSB first: 1,0,1,1,0,0,1,1
    ex_out = 8'b0000_0010;   // flag just before each bit
    @(negedge clk);
    // R1: held in reset
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, "R1");
    do_reset(1'b1);

    // R8: worked example
    check(ex_out[7], "R8");
    for (int i = 7; i >= 0; i--) begin
      step(ex_in[i], "R8");
      if (i > 0) begin
        checks++;
        if (flag_out !== ex_out[i-1]) begin
          errors++;
          $display("FAIL R8: flag_out=%b expected=%b", flag_out, ex_out[i-1]);
        end
      end
    end

    // R3: alternating 0/1 never sets double zero; odd ones keep flag low
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) step(i[0], "R3");
    check(1'b0, "R3");

    // R6: 0 before reset, 0 after reset is not a pair
    do_reset(1'b0);
    step(1'b0, "R6");
    do_reset(1'b0);
    step(1'b0, "R6");
    step(1'b1, "R6");
    check(1'b0, "R6");

    // R7 / R4 / R2: set flag then long runs of 1s and isolated 0s
    do_reset(1'b1);
    step(1'b0, "R3"); step(1'b0, "R3"); step(1'b1, "R5");
    check(1'b1, "R5");
    for (int i = 0; i < 12; i++) step(1'b1, "R7");
    step(1'b0, "R2"); step(1'b1, "R4"); step(1'b0, "R2");
    check(model_flag(), "R4");

    // random streams with occasional resets
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 200) == 0) do_reset($urandom % 2);
      else step((($urandom % 5) < 2), "R5");
    end

    // R1: reset mid-stream after flag high
    do_reset(1'b1);
    step(1'b0, "R5"); step(1'b0, "R5"); step(1'b1, "R5");
    do_reset(1'b1);
    check(1'b0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule